// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

This block is a periodic interval timer with a 64-bit period assembled from two 32-bit words. It counts single-cycle clock-enable pulses on `tick_i`, which stand in for an already selected and prescaled time base. When the count reaches the programmed period, the block sets a sticky period flag and pulses `irq_o` for one cycle. The count then wraps and the next period starts.

Software reaches the timer over a simple memory-mapped register bus. Each access is a single-cycle request with a combinational read path. A mode register selects between two behaviours:
- **Locked mode:** period writes are gated by a write-protect enable and are ignored while the timer runs. The START command loads the stored period.
- **Live mode:** period writes always pass. A write to the high word is staged. A write to the low word takes effect at once, together with the staged high word, and restarts the current period.

Top module: `ptmr_top`

## Requirements
- R1: After reset, the low period word (0x08), high period word (0x04), mode register (0x0C) and status register (0x10) all read as zero, and `irq_o` is low.
- R2: In locked mode (mode bit 0 = 0) with write protect set (mode bit 1 = 1), writes to 0x04 and 0x08 are dropped, and reads of those words return their previous values.
- R3: In locked mode, while the timer runs, writes to 0x04 and 0x08 are dropped. The running period is unchanged.
- R4: Writing 0x00 with bit 0 set (bit 1 clear) starts the timer. This loads the active period from {0x04, 0x08} and clears the counter.
- R5: With a period N > 0, `irq_o` is high for exactly the one cycle after every Nth tick since start. It is low at all other times.
- R6: A period of zero behaves as a period of one, so every tick raises `irq_o`.
- R7: In live mode (mode bit 0 = 1), a write to 0x08 is accepted even with write protect set. It clears the counter, so the next interrupt comes after N ticks counted from the write.
- R8: In live mode, a write to 0x04 changes only the read-back value. The active period picks up the new high word at the next write to 0x08.
- R9: Status bit 0 is a sticky period flag. It is set with each interrupt and cleared by a read of 0x10, and that read still returns the set value.
- R10: Status bit 1 reports running. Writing 0x00 with bit 1 set stops the timer and clears the counter; no interrupt follows while it is stopped.
- R11: When a control write has both bit 0 and bit 1 set, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable pulse from the selected time base |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | One-cycle period-elapsed interrupt |

## Verification
The bench targets the following corner cases:
- **Gating of period writes.** A design that applied protection in live mode, or ignored the running lock, would show changed read-back values or a shifted interrupt tick.
- **Zero period.** A design that took zero literally would stall and never interrupt.
- **Live-mode restart and high-word staging.** Mixing up staging would make the interrupt land at the old 4-tick cadence after the low write, or move the cadence on a high-word write alone.
- **Flag lifecycle and stop precedence.** A design that cleared the flag before returning it would read as never set. One where start beat stop would keep running.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 2 * WORD_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_PHI  = 5'h04;
  localparam logic [ADDR_W-1:0] A_PLO  = 5'h08;
  localparam logic [ADDR_W-1:0] A_MODE = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h10;

  localparam int unsigned B_START = 0;
  localparam int unsigned B_STOP  = 1;
  localparam int unsigned B_LIVE  = 0;
  localparam int unsigned B_WPROT = 1;
  localparam int unsigned B_FLAG  = 0;
  localparam int unsigned B_RUN   = 1;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              run_i,
  input  logic              flag_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              restart_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              flag_clr_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] hi_o,
  output logic              live_o,
  output logic              wprot_o
);
  logic [WORD_W-1:0] lo_q, hi_q;
  logic live_q, wprot_q;
  logic wr, rd, per_ok, wr_lo, wr_hi;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  // live mode bypasses both protection and the running lock
  assign per_ok = live_q | (~wprot_q & ~run_i);
  assign wr_lo  = wr & (addr_i == A_PLO) & per_ok;
  assign wr_hi  = wr & (addr_i == A_PHI) & per_ok;

  assign stop_o     = wr & (addr_i == A_CTRL) & wdata_i[B_STOP];
  assign start_o    = wr & (addr_i == A_CTRL) & wdata_i[B_START] & ~wdata_i[B_STOP];
  assign restart_o  = wr_lo & live_q;
  assign load_val_o = restart_o ? {hi_q, wdata_i} : {hi_q, lo_q};
  assign flag_clr_o = rd & (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      live_q  <= 1'b0;
      wprot_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata_i;
      if (wr_hi) hi_q <= wdata_i;
      if (wr && addr_i == A_MODE) begin
        live_q  <= wdata_i[B_LIVE];
        wprot_q <= wdata_i[B_WPROT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        A_PLO:   rdata_o = lo_q;
        A_PHI:   rdata_o = hi_q;
        A_MODE:  begin
          rdata_o[B_LIVE]  = live_q;
          rdata_o[B_WPROT] = wprot_q;
        end
        A_STAT:  begin
          rdata_o[B_FLAG] = flag_i;
          rdata_o[B_RUN]  = run_i;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign live_o  = live_q;
  assign wprot_o = wprot_q;
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             flag_clr_i,
  output logic             run_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] cnt_q, act_q, term;
  logic run_q, flag_q, irq_q, hit, ctl, evt;

  // zero period acts as one tick
  assign term = (act_q == '0) ? '0 : act_q - 1'b1;
  assign hit  = cnt_q >= term;
  assign ctl  = stop_i | start_i | restart_i;
  assign evt  = run_q & tick_i & hit & ~ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        act_q <= load_val_i;
      end else if (restart_i) begin
        cnt_q <= '0;
        act_q <= load_val_i;
      end else if (run_q && tick_i) begin
        if (hit) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // set has priority over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (evt)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign run_o  = run_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
  assign cnt_o  = cnt_q;
  assign act_o  = act_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  logic start, stop, restart, flag_clr, run, flag, live, wprot;
  logic [CNT_W-1:0]  load_val, cnt, act;
  logic [WORD_W-1:0] lo, hi;

  ptmr_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .run_i(run), .flag_i(flag),
    .start_o(start), .stop_o(stop), .restart_o(restart),
    .load_val_o(load_val), .flag_clr_o(flag_clr),
    .lo_o(lo), .hi_o(hi), .live_o(live), .wprot_o(wprot)
  );

  ptmr_core u_core (
    .clk_i, .rst_ni, .tick_i,
    .start_i(start), .stop_i(stop), .restart_i(restart),
    .load_val_i(load_val), .flag_clr_i(flag_clr),
    .run_o(run), .flag_o(flag), .irq_o, .cnt_o(cnt), .act_o(act)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              run,
  input logic              flag,
  input logic              live,
  input logic              wprot,
  input logic [WORD_W-1:0] lo,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  act
);
  logic w_lo, w_ctl;
  assign w_lo  = req_i & we_i & (addr_i == A_PLO);
  assign w_ctl = req_i & we_i & (addr_i == A_CTRL);

  AST_WPROT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_lo && wprot && !live) |=> $stable(lo)); // R2
  AST_RUN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_lo && run && !live) |=> $stable(lo)); // R3
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_ctl && wdata_i[B_START] && !wdata_i[B_STOP]) |=> (run && cnt == '0)); // R4
  AST_IRQ_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i && run)); // R5
  AST_ZERO_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == '0) |-> (cnt == '0)); // R6
  AST_LIVE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_lo && live) |=> (cnt == '0 && lo == $past(wdata_i))); // R7
  AST_FLAG_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag); // R9
  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_ctl && wdata_i[B_STOP]) |=> (!run && !irq_o)); // R10 R11
endmodule

bind ptmr_top ptmr_checker u_chk (
  .clk_i, .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .irq_o,
  .run, .flag, .live, .wprot, .lo, .cnt, .act
);

// File: tb/ptmr_top_test.sv
module ptmr_top_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ptmr_top uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic longint eff(input longint p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic check(input string r, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  // one tick; returns irq seen in the following cycle
  task automatic tk(output logic seen);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; seen = irq;
  endtask

  // run n ticks, count mismatches against a period p
  task automatic run_ticks(input int n, input longint p, output int bad);
    logic s;
    bad = 0;
    for (int i = 1; i <= n; i++) begin
      tk(s);
      if (s != ((i % eff(p)) == 0)) bad++;
      repeat ($urandom % 3) begin
        @(negedge clk);
        if (irq) bad++;
      end
    end
  endtask

  initial begin
    logic [31:0] d;
    int bad;
    longint p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(5'h08, d); check("R1 lo", d, 0);
    rd(5'h04, d); check("R1 hi", d, 0);
    rd(5'h0C, d); check("R1 mode", d, 0);
    rd(5'h10, d); check("R1 status", d, 0);
    check("R1 irq", irq, 0);

    wr(5'h0C, 32'h2);
    wr(5'h08, 32'h5); rd(5'h08, d); check("R2 lo dropped", d, 0);
    wr(5'h04, 32'h7); rd(5'h04, d); check("R2 hi dropped", d, 0);
    wr(5'h0C, 32'h0);
    wr(5'h08, 32'h3); rd(5'h08, d); check("R2 lo accepted", d, 3);

    wr(5'h00, 32'h1);
    rd(5'h10, d); check("R4 running", d, 2);
    run_ticks(6, 3, bad); check("R5 period 3", bad, 0);
    wr(5'h08, 32'h7); rd(5'h08, d); check("R3 lo locked", d, 3);
    wr(5'h04, 32'h1); rd(5'h04, d); check("R3 hi locked", d, 0);
    run_ticks(3, 3, bad); check("R3 period kept", bad, 0);

    rd(5'h10, d); check("R9 flag set", d, 3);
    rd(5'h10, d); check("R9 flag cleared", d, 2);

    wr(5'h00, 32'h2);
    rd(5'h10, d); check("R10 stopped", d, 0);
    run_ticks(4, 1000, bad); check("R10 no irq", bad, 0);

    wr(5'h08, 32'h0); wr(5'h00, 32'h1);
    run_ticks(4, 0, bad); check("R6 zero period", bad, 0);
    wr(5'h00, 32'h3);
    rd(5'h10, d); check("R11 stop wins", d[1], 0);

    // live mode with write protect set
    wr(5'h0C, 32'h3);
    wr(5'h08, 32'h4); rd(5'h08, d); check("R7 accepted", d, 4);
    wr(5'h00, 32'h1);
    run_ticks(2, 1000, bad); check("R7 pre ticks", bad, 0);
    wr(5'h08, 32'h4);
    run_ticks(4, 4, bad); check("R7 restart", bad, 0);
    wr(5'h04, 32'h1); rd(5'h04, d); check("R8 hi staged", d, 1);
    run_ticks(4, 4, bad); check("R8 active unchanged", bad, 0);
    wr(5'h08, 32'h4);
    run_ticks(8, 64'h1_0000_0004, bad); check("R8 hi applied", bad, 0);
    wr(5'h00, 32'h2); wr(5'h04, 32'h0); wr(5'h0C, 32'h0);

    for (int k = 0; k < 20; k++) begin
      p = $urandom % 6;
      wr(5'h08, p[31:0]); wr(5'h00, 32'h1);
      run_ticks(3 * int'(eff(p)), p, bad);
      check("R5 random period", bad, 0);
      wr(5'h00, 32'h2);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule